// File: doc/BRIEF.md
# Correlation Surface Peak Finder

This block watches a stream of non-negative correlation energies (squared magnitudes) delivered one per cycle in raster order, one full frame at a time. It keeps the running largest sample and where it sits, so that at the end of the frame the column and row of the strongest sample give the relative displacement between the two images that produced the surface. Because the samples are already squared magnitudes, no square root is taken anywhere.

The first sample of each frame, flagged by a start-of-frame input, sits at the origin cell. That sample is latched as a reference and also competes for the peak. Instead of normalising by a division, the block grades the result with one multiplier and one comparator. The peak is accepted when it is at least a programmable fixed-point fraction of the reference. One cycle after the final sample of the frame, a single-cycle done strobe comes out with the peak energy, its coordinates and the accept flag. These outputs then hold until the next frame completes.

Top module: `corr_peak_locator`

## Requirements
- R1: While rst_n is low at a clock edge, done, pk_pass, pk_value, pk_col and pk_row all become 0.
- R2: The sample carrying smp_sof is at column 0, row 0. Each later accepted sample moves one column to the right. After column COLS-1 it moves to column 0 of the next row. The reported pk_col and pk_row are the position of the peak sample.
- R3: pk_value is the largest unsigned smp_data among the COLS*ROWS samples of the frame.
- R4: When several samples share the largest value, the one earliest in raster order is reported.
- R5: The origin sample is latched as the reference and also competes for the peak. If it is the largest, the result is column 0, row 0, and pk_value is never below the reference.
- R6: thr_frac is unsigned with FRAC_W fractional bits (value thr_frac/2^FRAC_W). It is sampled in the cycle of the frame's last sample. pk_pass is 1 exactly when pk_value*2^FRAC_W >= thr_frac*reference, compared at full product width.
- R7: done is high for exactly the one cycle after the edge that takes the frame's last sample. Between done strobes, pk_value, pk_col, pk_row and pk_pass do not change.
- R8: Cycles with smp_valid low are ignored. They neither advance the position nor affect the search.
- R9: A start-of-frame in the middle of a frame abandons it. The running maximum and the reference are discarded, and counting restarts at the origin.
- R10: Samples with smp_valid high that arrive outside a frame (before any start-of-frame, or after a frame has finished) are ignored and produce no done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid | input | 1 | smp_data carries a sample this cycle |
| smp_sof | input | 1 | This sample is the origin of a new frame |
| smp_data | input | DATA_W | Unsigned squared-magnitude sample |
| thr_frac | input | THR_W | Acceptance fraction, FRAC_W fractional bits |
| done | output | 1 | One-cycle strobe: frame result is ready |
| pk_value | output | DATA_W | Largest sample of the last frame |
| pk_col | output | COL_W | Column of the peak |
| pk_row | output | ROW_W | Row of the peak |
| pk_pass | output | 1 | Peak meets the fraction of the origin value |

## Verification
The bench builds the block with a 6 by 5 frame, 16-bit samples and a 9-bit threshold with 8 fractional bits. The column count is not a power of two, so the column wrap into the next row is checked at a boundary that is not a natural counter overflow. A frame that short lets the run cover many frames: ties, an origin peak, an abandoned frame, back-to-back frames and gaps in valid. The 9-bit threshold reaches fractions above one, so the accept flag can be driven to the exact product boundary from both sides.

// File: rtl/corr_pk_pkg.sv
// Package: shared types for the correlation peak finder.
// Assumes: nothing beyond IEEE 1800-2017.
package corr_pk_pkg;

    // Raster tracker state: waiting for a frame, or inside one.
    typedef enum logic {
        TRK_IDLE = 1'b0,
        TRK_SCAN = 1'b1
    } trk_state_e;

    // Width of a coordinate counter for a dimension of n cells (at least 1 bit).
    function automatic int coord_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/corr_pk_raster.sv
// Module: raster position tracker.
// Tells which cell each accepted sample occupies. It accepts a sample when
// valid is high and either start-of-frame is set or a frame is open. It also
// flags the final cell of the frame.
// Assumes: COLS and ROWS are at least 1; start-of-frame forces position (0,0).
module corr_pk_raster #(
    parameter int COLS  = 256,
    parameter int ROWS  = 256,
    parameter int COL_W = 8,
    parameter int ROW_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_valid,
    input  logic             smp_sof,
    output logic             accept,
    output logic             is_last,
    output logic [COL_W-1:0] cur_col,
    output logic [ROW_W-1:0] cur_row
);
    import corr_pk_pkg::*;

    localparam logic [COL_W-1:0] LAST_COL = COL_W'(COLS - 1);
    localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(ROWS - 1);

    trk_state_e       state_q;
    logic [COL_W-1:0] col_q;
    logic [ROW_W-1:0] row_q;

    // Decide acceptance and the position of the current sample.
    always_comb begin
        accept  = smp_valid && (smp_sof || (state_q == TRK_SCAN));
        cur_col = smp_sof ? '0 : col_q;
        cur_row = smp_sof ? '0 : row_q;
        is_last = accept && (cur_col == LAST_COL) && (cur_row == LAST_ROW);
    end

    // Advance the raster position and open/close the frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TRK_IDLE;
            col_q   <= '0;
            row_q   <= '0;
        end else if (accept) begin
            if (is_last) begin
                state_q <= TRK_IDLE;
                col_q   <= '0;
                row_q   <= '0;
            end else begin
                state_q <= TRK_SCAN;
                if (cur_col == LAST_COL) begin
                    col_q <= '0;
                    row_q <= cur_row + 1'b1;
                end else begin
                    col_q <= cur_col + 1'b1;
                    row_q <= cur_row;
                end
            end
        end
    end

endmodule

// File: rtl/corr_pk_search.sv
// Module: running maximum and origin reference.
// Keeps the largest accepted sample and its coordinates. A sample must be
// strictly greater to displace the current best, so the first maximum in
// raster order wins. Start-of-frame seeds both the best value and the
// reference with the origin sample.
// Assumes: samples are unsigned; acceptance comes from the raster tracker.
module corr_pk_search #(
    parameter int DATA_W = 32,
    parameter int COL_W  = 8,
    parameter int ROW_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              smp_sof,
    input  logic [DATA_W-1:0] smp_data,
    input  logic [COL_W-1:0]  cur_col,
    input  logic [ROW_W-1:0]  cur_row,
    output logic [DATA_W-1:0] nxt_val,
    output logic [COL_W-1:0]  nxt_col,
    output logic [ROW_W-1:0]  nxt_row,
    output logic [DATA_W-1:0] nxt_ref,
    output logic [DATA_W-1:0] ref_val
);
    logic [DATA_W-1:0] best_q;
    logic [COL_W-1:0]  bcol_q;
    logic [ROW_W-1:0]  brow_q;
    logic [DATA_W-1:0] ref_q;

    // Work out the best value and reference including this sample.
    always_comb begin
        nxt_val = best_q;
        nxt_col = bcol_q;
        nxt_row = brow_q;
        nxt_ref = ref_q;
        if (accept && smp_sof) begin
            nxt_val = smp_data;
            nxt_col = '0;
            nxt_row = '0;
            nxt_ref = smp_data;
        end else if (accept && (smp_data > best_q)) begin
            nxt_val = smp_data;
            nxt_col = cur_col;
            nxt_row = cur_row;
        end
    end

    // Hold the running best and reference.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            best_q <= '0;
            bcol_q <= '0;
            brow_q <= '0;
            ref_q  <= '0;
        end else begin
            best_q <= nxt_val;
            bcol_q <= nxt_col;
            brow_q <= nxt_row;
            ref_q  <= nxt_ref;
        end
    end

    assign ref_val = ref_q;

endmodule

// File: rtl/corr_pk_judge.sv
// Module: confidence judge.
// Tests peak >= (thr / 2^FRAC_W) * reference without a divider. It compares
// the peak shifted up by FRAC_W bits against thr times the reference, both at
// full product width.
// Assumes: FRAC_W <= THR_W; all operands unsigned.
module corr_pk_judge #(
    parameter int DATA_W = 32,
    parameter int THR_W  = 9,
    parameter int FRAC_W = 8
) (
    input  logic [DATA_W-1:0] peak,
    input  logic [DATA_W-1:0] origin,
    input  logic [THR_W-1:0]  thr,
    output logic              pass
);
    localparam int PROD_W = DATA_W + THR_W;

    logic [PROD_W-1:0] lhs;
    logic [PROD_W-1:0] rhs;

    // Scale the peak and the reference to a common fixed point and compare.
    always_comb begin
        lhs  = PROD_W'({peak, {FRAC_W{1'b0}}});
        rhs  = PROD_W'(origin) * PROD_W'(thr);
        pass = (lhs >= rhs);
    end

endmodule

// File: rtl/corr_peak_locator.sv
// Module: correlation surface peak finder (top).
// Scans one frame of squared-magnitude samples in raster order and reports
// the peak value, its column and row, and whether it reaches a programmable
// fraction of the origin sample. The result is registered on the last sample
// and strobed by done one cycle later.
// Assumes: samples arrive one per cycle when smp_valid is high.
module corr_peak_locator #(
    parameter int COLS   = 256,
    parameter int ROWS   = 256,
    parameter int DATA_W = 32,
    parameter int THR_W  = 9,
    parameter int FRAC_W = 8,
    parameter int COL_W  = corr_pk_pkg::coord_width(COLS),
    parameter int ROW_W  = corr_pk_pkg::coord_width(ROWS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic              smp_sof,
    input  logic [DATA_W-1:0] smp_data,
    input  logic [THR_W-1:0]  thr_frac,
    output logic              done,
    output logic [DATA_W-1:0] pk_value,
    output logic [COL_W-1:0]  pk_col,
    output logic [ROW_W-1:0]  pk_row,
    output logic              pk_pass
);
    logic              accept;
    logic              is_last;
    logic [COL_W-1:0]  cur_col;
    logic [ROW_W-1:0]  cur_row;
    logic [DATA_W-1:0] nxt_val;
    logic [COL_W-1:0]  nxt_col;
    logic [ROW_W-1:0]  nxt_row;
    logic [DATA_W-1:0] nxt_ref;
    logic [DATA_W-1:0] ref_val;
    logic              judge_pass;

    corr_pk_raster #(
        .COLS (COLS),
        .ROWS (ROWS),
        .COL_W(COL_W),
        .ROW_W(ROW_W)
    ) u_raster (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp_valid(smp_valid),
        .smp_sof  (smp_sof),
        .accept   (accept),
        .is_last  (is_last),
        .cur_col  (cur_col),
        .cur_row  (cur_row)
    );

    corr_pk_search #(
        .DATA_W(DATA_W),
        .COL_W (COL_W),
        .ROW_W (ROW_W)
    ) u_search (
        .clk     (clk),
        .rst_n   (rst_n),
        .accept  (accept),
        .smp_sof (smp_sof),
        .smp_data(smp_data),
        .cur_col (cur_col),
        .cur_row (cur_row),
        .nxt_val (nxt_val),
        .nxt_col (nxt_col),
        .nxt_row (nxt_row),
        .nxt_ref (nxt_ref),
        .ref_val (ref_val)
    );

    corr_pk_judge #(
        .DATA_W(DATA_W),
        .THR_W (THR_W),
        .FRAC_W(FRAC_W)
    ) u_judge (
        .peak  (nxt_val),
        .origin(nxt_ref),
        .thr   (thr_frac),
        .pass  (judge_pass)
    );

    // Capture the frame result on the last sample and strobe done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done     <= 1'b0;
            pk_value <= '0;
            pk_col   <= '0;
            pk_row   <= '0;
            pk_pass  <= 1'b0;
        end else begin
            done <= is_last;
            if (is_last) begin
                pk_value <= nxt_val;
                pk_col   <= nxt_col;
                pk_row   <= nxt_row;
                pk_pass  <= judge_pass;
            end
        end
    end

endmodule

// File: rtl/corr_peak_locator_chk.sv
// Module: assertion checker for the peak finder, bound to the top.
// Assumes: reset is synchronous, active low.
module corr_peak_locator_chk #(
    parameter int COLS   = 256,
    parameter int ROWS   = 256,
    parameter int DATA_W = 32,
    parameter int THR_W  = 9,
    parameter int COL_W  = 8,
    parameter int ROW_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              smp_valid,
    input logic [THR_W-1:0]  thr_frac,
    input logic              done,
    input logic [DATA_W-1:0] pk_value,
    input logic [COL_W-1:0]  pk_col,
    input logic [ROW_W-1:0]  pk_row,
    input logic              pk_pass,
    input logic [DATA_W-1:0] ref_val
);
    localparam bit MULTI_CELL = (COLS * ROWS) > 1;

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && MULTI_CELL) |=> !done); // R7
    AST_DONE_AFTER_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(smp_valid)); // R7
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(pk_value) && $stable(pk_col) && $stable(pk_row) && $stable(pk_pass))); // R7
    AST_COORD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((pk_col <= COL_W'(COLS - 1)) && (pk_row <= ROW_W'(ROWS - 1)))); // R2
    AST_ORIGIN_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (pk_value >= ref_val)); // R5
    AST_ZERO_THR_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ($past(thr_frac) == '0)) |-> pk_pass); // R6

endmodule

bind corr_peak_locator corr_peak_locator_chk #(
    .COLS  (COLS),
    .ROWS  (ROWS),
    .DATA_W(DATA_W),
    .THR_W (THR_W),
    .COL_W (COL_W),
    .ROW_W (ROW_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .smp_valid(smp_valid),
    .thr_frac (thr_frac),
    .done     (done),
    .pk_value (pk_value),
    .pk_col   (pk_col),
    .pk_row   (pk_row),
    .pk_pass  (pk_pass),
    .ref_val  (ref_val)
);

// File: tb/sim_corr_peak_locator.sv
// Bench: behavioural reference model (queues, integers) compared every clock.
module sim_corr_peak_locator;
    localparam int COLS   = 6;
    localparam int ROWS   = 5;
    localparam int NPIX   = COLS * ROWS;
    localparam int DATA_W = 16;
    localparam int THR_W  = 9;
    localparam int FRAC_W = 8;
    localparam int COL_W  = 3;
    localparam int ROW_W  = 3;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic              rst_n = 1'b0;
    logic              smp_valid = 1'b0;
    logic              smp_sof = 1'b0;
    logic [DATA_W-1:0] smp_data = '0;
    logic [THR_W-1:0]  thr_frac = '0;
    logic              done;
    logic [DATA_W-1:0] pk_value;
    logic [COL_W-1:0]  pk_col;
    logic [ROW_W-1:0]  pk_row;
    logic              pk_pass;

    corr_peak_locator #(
        .COLS(COLS), .ROWS(ROWS), .DATA_W(DATA_W),
        .THR_W(THR_W), .FRAC_W(FRAC_W)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_sof(smp_sof),
        .smp_data(smp_data), .thr_frac(thr_frac), .done(done),
        .pk_value(pk_value), .pk_col(pk_col), .pk_row(pk_row), .pk_pass(pk_pass)
    );

    int    checks = 0;
    int    fails  = 0;
    int    cycles = 0;
    string phase  = "R1";

    task automatic chk(string what, longint got, longint exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s %s: got %0d expected %0d", phase, what, got, exp);
        end
    endtask

    // Reference model: collects the frame in a queue, scans it at the end.
    bit          m_active = 0;
    longint      mq[$];
    longint      m_ref = 0;
    bit          m_done = 0;
    longint      m_val = 0;
    int          m_col = 0;
    int          m_row = 0;
    bit          m_pass = 0;
    int          bi;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_active = 0; mq.delete(); m_ref = 0; m_done = 0;
            m_val = 0; m_col = 0; m_row = 0; m_pass = 0;
        end else begin
            m_done = 0;
            if (smp_valid && (smp_sof || m_active)) begin
                if (smp_sof) begin
                    mq.delete();
                    m_ref = smp_data;
                end
                m_active = 1;
                mq.push_back(longint'(smp_data));
                if (mq.size() == NPIX) begin
                    bi = 0;
                    for (int i = 1; i < NPIX; i++) if (mq[i] > mq[bi]) bi = i;
                    m_val  = mq[bi];
                    m_col  = bi % COLS;
                    m_row  = bi / COLS;
                    m_pass = (m_val * (longint'(1) << FRAC_W)) >= (m_ref * longint'(thr_frac));
                    m_done = 1;
                    m_active = 0;
                    mq.delete();
                end
            end
        end
    end

    // Compare every cycle away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            chk("done", done, m_done);                       // R7
            chk("pk_value", pk_value, m_val);                // R3
            chk("pk_col", pk_col, m_col);                    // R2
            chk("pk_row", pk_row, m_row);                    // R2
            chk("pk_pass", pk_pass, m_pass);                 // R6
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            fails++;
            $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    task automatic drive(bit v, bit s, int unsigned d);
        @(negedge clk);
        smp_valid = v;
        smp_sof   = s;
        smp_data  = d[DATA_W-1:0];
    endtask

    task automatic send_frame(longint v[$], bit gaps, bit trail);
        for (int i = 0; i < v.size(); i++) begin
            if (gaps && (i % 4 == 2)) drive(1'b0, 1'b1, 16'hFFFF); // valid low: ignored (R8)
            drive(1'b1, i == 0, int'(v[i]));
        end
        if (trail) drive(1'b0, 1'b0, 0);
    endtask

    longint fr[$];

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 done", done, 0);
        chk("R1 pk_value", pk_value, 0);
        chk("R1 pk_col", pk_col, 0);
        chk("R1 pk_row", pk_row, 0);
        chk("R1 pk_pass", pk_pass, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R10: valid samples with no frame open
        phase = "R10";
        for (int i = 0; i < 2 * NPIX; i++) drive(1'b1, 1'b0, 60000 + i);
        drive(1'b0, 1'b0, 0);
        repeat (2) @(negedge clk);
        chk("R10 no done", done, 0);

        // R3: random frame, typical threshold
        phase = "R3";
        thr_frac = 9'd205;
        for (int k = 0; k < 4; k++) begin
            fr = {};
            for (int i = 0; i < NPIX; i++) fr.push_back(longint'($urandom_range(0, 65535)));
            send_frame(fr, 1'b0, 1'b1);
        end

        // R10: samples after a finished frame
        phase = "R10";
        for (int i = 0; i < 5; i++) drive(1'b1, 1'b0, 65535);
        drive(1'b0, 1'b0, 0);
        repeat (2) @(negedge clk);

        // R8: gaps in valid
        phase = "R8";
        for (int k = 0; k < 3; k++) begin
            fr = {};
            for (int i = 0; i < NPIX; i++) fr.push_back(longint'($urandom_range(0, 40000)));
            send_frame(fr, 1'b1, 1'b1);
        end

        // R2: peak at end of first row (column wrap) and at last cell
        phase = "R2";
        fr = {};
        for (int i = 0; i < NPIX; i++) fr.push_back(i == COLS - 1 ? 900 : 10 + i);
        send_frame(fr, 1'b0, 1'b1);
        fr = {};
        for (int i = 0; i < NPIX; i++) fr.push_back(i == NPIX - 1 ? 901 : 10 + i);
        send_frame(fr, 1'b0, 1'b1);

        // R4: ties keep the first in raster order
        phase = "R4";
        fr = {};
        for (int i = 0; i < NPIX; i++) fr.push_back((i == 7 || i == 20) ? 5000 : 100 + i);
        send_frame(fr, 1'b0, 1'b1);
        chk("R4 tie col", pk_col, 1);
        chk("R4 tie row", pk_row, 1);

        // R5: origin is the peak; all-equal frame
        phase = "R5";
        fr = {};
        for (int i = 0; i < NPIX; i++) fr.push_back(i == 0 ? 30000 : 200 + i);
        send_frame(fr, 1'b0, 1'b1);
        chk("R5 origin col", pk_col, 0);
        chk("R5 origin row", pk_row, 0);
        fr = {};
        for (int i = 0; i < NPIX; i++) fr.push_back(777);
        send_frame(fr, 1'b0, 1'b1);

        // R6: exact boundary of the fraction test (1.5 * 100 = 150)
        phase = "R6";
        thr_frac = 9'd384;
        fr = {};
        for (int i = 0; i < NPIX; i++) fr.push_back(i == 0 ? 100 : (i == 13 ? 150 : 50));
        send_frame(fr, 1'b0, 1'b1);
        chk("R6 pass at boundary", pk_pass, 1);
        fr[13] = 149;
        send_frame(fr, 1'b0, 1'b1);
        chk("R6 fail below boundary", pk_pass, 0);
        thr_frac = 9'd0;
        send_frame(fr, 1'b0, 1'b1);
        thr_frac = 9'd511;
        fr = {};
        for (int i = 0; i < NPIX; i++) fr.push_back(i == 0 ? 65535 : 1);
        send_frame(fr, 1'b0, 1'b1);
        chk("R6 wide product fail", pk_pass, 0);

        // R9: restart in the middle of a frame
        phase = "R9";
        thr_frac = 9'd230;
        for (int i = 0; i < 10; i++) drive(1'b1, i == 0, i == 3 ? 65000 : 40000);
        fr = {};
        for (int i = 0; i < NPIX; i++) fr.push_back(300 + (i * 7) % 50);
        send_frame(fr, 1'b0, 1'b1);
        chk("R9 stale max dropped", pk_value, 349);

        // R7: back-to-back frames
        phase = "R7";
        for (int k = 0; k < 3; k++) begin
            fr = {};
            for (int i = 0; i < NPIX; i++) fr.push_back(longint'($urandom_range(0, 65535)));
            send_frame(fr, 1'b0, 1'b0);
        end
        drive(1'b0, 1'b0, 0);
        repeat (4) @(negedge clk);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule